// File: doc/BRIEF.md
# Event Logging Mission Controller

This block runs one recording session ("mission") of an event logger. Once started, it keeps an elapsed-interval counter that advances on a selectable real-time tick, which can be seconds, minutes or hours. On every qualified event it stores the counter value as a two-byte entry in a byte-wide log RAM, then restarts the counter. It also counts events, requests a start time-stamp capture, and writes the two-byte "event 0" delta register next to that stamp.

Starting is tamper-resistant. A mission only begins after a two-step clear has wiped the log and all counters. Any host write during a mission ends it, and a stopped log cannot be restarted without another clear. Three further cases are handled:

- A counter that saturates before an event is stored as a continuation entry.
- When the log fills with rollover disabled, further entries are dropped.
- When the log fills with rollover enabled, the next event re-stamps the start time and saves the last delta, and new entries then wrap to address 0.

Top module: `evlog_mission_ctrl`

## Requirements
- R1: After reset, mission, armed, memory-cleared, clear-enable, busy and wrap flags are 0; the event count, interval counter and write pointer are 0; and no log byte is written.
- R2: A clear-enable command followed directly by a clear-memory command raises busy. The clear then writes 0 to every log byte in ascending address order, one byte per cycle. It also zeroes the event count, interval counter, write pointer and wrap flag, pulses the stamp-clear output, and writes 0 to the event 0 register. It ends by setting memory-cleared and dropping busy. Any other command after clear-enable cancels it, and no clear happens.
- R3: A start by either path is refused unless all four of these hold: memory-cleared is 1, trigger select is not 00, resolution select is not 00, and oscillator enable is 1. An arm request under these failing conditions leaves the armed flag at 0.
- R4: Writing 1 to the mission bit starts a mission at once. On the following cycle the mission and armed flags are 1, memory-cleared is 0, and the event count is 1. In that same cycle the stamp-capture and event-0 write strobes pulse, with an event 0 value of 0.
- R5: Writing 1 to the arm bit sets the armed flag only. The next qualified event then starts the mission with the effects of R4. That event writes no log entry.
- R6: During a mission the interval counter advances on the seconds tick when resolution select is 01, on the minutes tick when it is 10, and on the hours tick when it is 11. The two unselected ticks have no effect.
- R7: Each event in a mission stores the counter value as an entry. The low byte goes to the even address at the write pointer, and the high byte goes to the next odd address on the following cycle. The pointer then advances by 2, the counter restarts at 0 and the event count rises by 1.
- R8: If the counter reaches 0xFFFF before an event, 0xFFFF is stored as an entry and the pointer advances by 2. The counter restarts from 0 and the event count is unchanged.
- R9: With rollover disabled, once the entry written at bytes 0x7FE/0x7FF wraps the pointer to 0, the wrap flag is set. No further log bytes are written, but events are still counted.
- R10: With rollover enabled and the log full, the next event does five things: it pulses stamp capture, writes the counter value to the event 0 register, sets the wrap flag, writes no log byte, and counts the event. The entry after that goes to address 0.
- R11: Any host command during a mission stops it. Mission and armed flags clear once any entry in progress has been written, and the interval counter stops advancing.
- R12: Outside a mission, when not armed, events write no log byte and do not change the event count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Qualified event strobe, one cycle, at least 4 cycles apart |
| tick_sec_i | input | 1 | Seconds-unit tick strobe |
| tick_min_i | input | 1 | Minutes-unit tick strobe |
| tick_hr_i | input | 1 | Hours-unit tick strobe |
| res_sel_i | input | 2 | Resolution select: 00 off, 01 s, 10 min, 11 h |
| trig_sel_i | input | 2 | Trigger select (00 is invalid) |
| osc_en_i | input | 1 | Oscillator running |
| roll_en_i | input | 1 | Rollover mode enable |
| arm_wr_i | input | 1 | Host write of the arm bit |
| arm_val_i | input | 1 | Value written with arm_wr_i |
| mip_wr_i | input | 1 | Host write of the mission bit |
| mip_val_i | input | 1 | Value written with mip_wr_i |
| clren_wr_i | input | 1 | Host write setting clear-enable |
| clrmem_wr_i | input | 1 | Host write setting clear-memory |
| reg_wr_i | input | 1 | Host write to any other register |
| log_we_o | output | 1 | Log RAM byte write enable |
| log_addr_o | output | 11 | Log RAM byte address |
| log_wdata_o | output | 8 | Log RAM write data |
| stamp_cap_o | output | 1 | Capture current time into start stamp |
| stamp_clr_o | output | 1 | Zero the start stamp |
| ev0_we_o | output | 1 | Write strobe of the event 0 delta register |
| ev0_val_o | output | 16 | Value for the event 0 delta register |
| mip_o | output | 1 | Mission in progress |
| me_o | output | 1 | Armed / mission enable |
| mem_clr_o | output | 1 | Memory-cleared flag |
| clr_en_o | output | 1 | Clear-enable flag |
| busy_o | output | 1 | Clear sweep running |
| rof_o | output | 1 | Log has wrapped |
| etc_o | output | 16 | Interval counter |
| evt_cnt_o | output | 24 | Event count |
| wptr_o | output | 11 | Next log byte address |

## Verification
Several rules are checked on every cycle:

- A mission never begins without a cleared memory and a valid configuration.
- The start strobes coincide with the rise of the mission flag.
- The armed flag is low whenever the mission flag falls.
- The event count never moves by more than one except through a clear.
- A high log byte always follows its low byte at the next address.
- No byte is written while the log stays full.
- The interval counter holds still outside a mission or with resolution off.
- Busy never overlaps a mission.

The stored entry values, the tick selection, the saturation entry, the full and rollover sequences and the cancelled clear can only be shown by the bench's scenarios. For these, the bench compares the log contents and counters against tick counts it drives itself.

// File: rtl/evlog_pkg.sv
package evlog_pkg;

    // Interval counter width; an entry is two log bytes.
    localparam int unsigned EV_ETC_W = 16;

    typedef enum logic [1:0] {
        RES_OFF = 2'b00,
        RES_SEC = 2'b01,
        RES_MIN = 2'b10,
        RES_HR  = 2'b11
    } res_sel_e;

    typedef enum logic [1:0] {
        WP_IDLE,
        WP_HI,
        WP_SWEEP
    } wp_state_e;

    typedef struct packed {
        logic                en;
        logic [EV_ETC_W-1:0] val;
    } entry_req_t;

    function automatic logic start_ok(input logic cleared, input logic [1:0] trig,
                                      input res_sel_e res, input logic osc);
        return cleared && (trig != 2'b00) && (res != RES_OFF) && osc;
    endfunction

endpackage

// File: rtl/evlog_etc.sv
module evlog_etc
    import evlog_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                restart,
    input  res_sel_e            res_sel,
    input  logic                tick_sec,
    input  logic                tick_min,
    input  logic                tick_hr,
    output logic [EV_ETC_W-1:0] etc_o,
    output logic                sat_o
);
    logic [EV_ETC_W-1:0] etc_q;
    logic                step;

    always_comb begin
        case (res_sel)
            RES_SEC: step = tick_sec;
            RES_MIN: step = tick_min;
            RES_HR:  step = tick_hr;
            default: step = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            etc_q <= '0;
        end else if (run && step && !sat_o) begin
            etc_q <= etc_q + EV_ETC_W'(1);
        end
    end

    assign sat_o = run && (etc_q == '1);
    assign etc_o = etc_q;

    AST_ETC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(etc_q)); // R11
    AST_ETC_OFF_RES: assert property (@(posedge clk) disable iff (rst)
        (res_sel == RES_OFF && !restart) |=> $stable(etc_q)); // R6

endmodule

// File: rtl/evlog_writer.sv
module evlog_writer
    import evlog_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  entry_req_t        req,
    input  logic              sweep_go,
    input  logic              rearm,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        data_o,
    output logic [ADDR_W-1:0] wptr_o,
    output logic              full_o,
    output logic              wrap_o,
    output logic              idle_o,
    output logic              sweep_done_o
);
    localparam logic [ADDR_W-1:0] LAST = '1;
    localparam int unsigned       HI_W = EV_ETC_W - 8;

    wp_state_e         state_q;
    logic [ADDR_W-1:0] wptr_q, cnt_q, addr_q;
    logic [7:0]        data_q;
    logic [HI_W-1:0]   hi_q;
    logic              we_q, full_q;
    entry_req_t        pend_q, nxt;
    logic              last_pair;

    assign nxt       = pend_q.en ? pend_q : req;
    assign last_pair = &wptr_q[ADDR_W-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WP_IDLE;
            wptr_q  <= '0;
            cnt_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            hi_q    <= '0;
            we_q    <= 1'b0;
            full_q  <= 1'b0;
            pend_q  <= '0;
        end else begin
            we_q <= 1'b0;
            if (sweep_go) begin
                state_q <= WP_SWEEP;
                cnt_q   <= ADDR_W'(1);
                we_q    <= 1'b1;
                addr_q  <= '0;
                data_q  <= '0;
                wptr_q  <= '0;
                full_q  <= 1'b0;
                pend_q  <= '0;
            end else begin
                if (rearm) full_q <= 1'b0;
                case (state_q)
                    WP_SWEEP: begin
                        we_q   <= 1'b1;
                        addr_q <= cnt_q;
                        data_q <= '0;
                        cnt_q  <= cnt_q + ADDR_W'(1);
                        if (cnt_q == LAST) state_q <= WP_IDLE;
                    end
                    WP_HI: begin
                        we_q    <= 1'b1;
                        addr_q  <= {wptr_q[ADDR_W-1:1], 1'b1};
                        data_q  <= hi_q;
                        wptr_q  <= wptr_q + ADDR_W'(2);
                        if (last_pair) full_q <= 1'b1;
                        state_q <= WP_IDLE;
                        if (req.en) pend_q <= req;
                    end
                    default: begin
                        pend_q <= pend_q.en ? req : '0;
                        if (nxt.en && !full_q) begin
                            we_q    <= 1'b1;
                            addr_q  <= wptr_q;
                            data_q  <= nxt.val[7:0];
                            hi_q    <= nxt.val[EV_ETC_W-1:8];
                            state_q <= WP_HI;
                        end
                    end
                endcase
            end
        end
    end

    assign we_o         = we_q;
    assign addr_o       = addr_q;
    assign data_o       = data_q;
    assign wptr_o       = wptr_q;
    assign full_o       = full_q;
    assign wrap_o       = (state_q == WP_HI) && last_pair && !sweep_go;
    assign idle_o       = (state_q == WP_IDLE) && !pend_q.en;
    assign sweep_done_o = (state_q == WP_SWEEP) && (cnt_q == LAST) && !sweep_go;

    AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (rst)
        (we_q && !addr_q[0]) |=> (we_q && addr_q == $past(addr_q) + ADDR_W'(1))); // R7
    AST_QUIET_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (full_q && $past(full_q)) |-> !we_q); // R9

endmodule

// File: rtl/evlog_mission_ctrl.sv
module evlog_mission_ctrl
    import evlog_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned CNT_W  = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                evt_i,
    input  logic                tick_sec_i,
    input  logic                tick_min_i,
    input  logic                tick_hr_i,
    input  logic [1:0]          res_sel_i,
    input  logic [1:0]          trig_sel_i,
    input  logic                osc_en_i,
    input  logic                roll_en_i,
    input  logic                arm_wr_i,
    input  logic                arm_val_i,
    input  logic                mip_wr_i,
    input  logic                mip_val_i,
    input  logic                clren_wr_i,
    input  logic                clrmem_wr_i,
    input  logic                reg_wr_i,
    output logic                log_we_o,
    output logic [ADDR_W-1:0]   log_addr_o,
    output logic [7:0]          log_wdata_o,
    output logic                stamp_cap_o,
    output logic                stamp_clr_o,
    output logic                ev0_we_o,
    output logic [EV_ETC_W-1:0] ev0_val_o,
    output logic                mip_o,
    output logic                me_o,
    output logic                mem_clr_o,
    output logic                clr_en_o,
    output logic                busy_o,
    output logic                rof_o,
    output logic [EV_ETC_W-1:0] etc_o,
    output logic [CNT_W-1:0]    evt_cnt_o,
    output logic [ADDR_W-1:0]   wptr_o
);
    res_sel_e            res_e;
    logic                mip_q, me_q, memclr_q, clren_q, busy_q, rof_q, stop_q;
    logic                stamp_q, stampclr_q, ev0we_q;
    logic [EV_ETC_W-1:0] ev0val_q, etc;
    logic [CNT_W-1:0]    cnt_q;
    logic                any_cmd, cfg_ok, host_free, active;
    logic                start_imm, start_arm, start, ev, ev_store, ev_roll, sat, sat_hit;
    logic                sweep_go, full, wrap, wr_idle, sweep_done;
    entry_req_t          req;

    assign res_e     = res_sel_e'(res_sel_i);
    assign any_cmd   = arm_wr_i | mip_wr_i | clren_wr_i | clrmem_wr_i | reg_wr_i;
    assign cfg_ok    = start_ok(memclr_q, trig_sel_i, res_e, osc_en_i);
    assign host_free = !busy_q && !mip_q;
    assign active    = mip_q && !stop_q;

    assign start_imm = host_free && mip_wr_i && mip_val_i && cfg_ok;
    assign start_arm = host_free && me_q && evt_i && cfg_ok && !any_cmd;
    assign start     = start_imm || start_arm;
    assign sweep_go  = host_free && clrmem_wr_i && clren_q;

    assign ev       = active && evt_i;
    assign ev_store = ev && !full;
    assign ev_roll  = ev && full && roll_en_i;
    assign sat_hit  = active && sat && !ev;
    assign req.en   = ev_store || (sat_hit && !full);
    assign req.val  = ev_store ? etc : '1;

    evlog_etc u_etc (
        .clk      (clk),
        .rst      (rst),
        .run      (active),
        .restart  (ev || sat_hit || start || sweep_go),
        .res_sel  (res_e),
        .tick_sec (tick_sec_i),
        .tick_min (tick_min_i),
        .tick_hr  (tick_hr_i),
        .etc_o    (etc),
        .sat_o    (sat)
    );

    evlog_writer #(.ADDR_W(ADDR_W)) u_writer (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .sweep_go     (sweep_go),
        .rearm        (ev_roll),
        .we_o         (log_we_o),
        .addr_o       (log_addr_o),
        .data_o       (log_wdata_o),
        .wptr_o       (wptr_o),
        .full_o       (full),
        .wrap_o       (wrap),
        .idle_o       (wr_idle),
        .sweep_done_o (sweep_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mip_q <= 1'b0; me_q <= 1'b0; memclr_q <= 1'b0; clren_q <= 1'b0;
            busy_q <= 1'b0; rof_q <= 1'b0; stop_q <= 1'b0;
            stamp_q <= 1'b0; stampclr_q <= 1'b0; ev0we_q <= 1'b0;
            ev0val_q <= '0; cnt_q <= '0;
        end else begin
            stamp_q    <= 1'b0;
            stampclr_q <= 1'b0;
            ev0we_q    <= 1'b0;
            if (!busy_q && any_cmd) clren_q <= clren_wr_i;
            if (host_free && arm_wr_i) me_q <= arm_val_i && cfg_ok;
            if (start) begin
                mip_q    <= 1'b1;
                me_q     <= 1'b1;
                memclr_q <= 1'b0;
                cnt_q    <= cnt_q + CNT_W'(1);
                stamp_q  <= 1'b1;
                ev0we_q  <= 1'b1;
                ev0val_q <= '0;
            end
            if (mip_q && any_cmd) stop_q <= 1'b1;
            if (stop_q && wr_idle) begin
                mip_q  <= 1'b0;
                me_q   <= 1'b0;
                stop_q <= 1'b0;
            end
            if (ev) cnt_q <= cnt_q + CNT_W'(1);
            if (ev_roll) begin
                stamp_q  <= 1'b1;
                ev0we_q  <= 1'b1;
                ev0val_q <= etc;
                rof_q    <= 1'b1;
            end
            if (wrap && !roll_en_i) rof_q <= 1'b1;
            if (sweep_go) begin
                busy_q     <= 1'b1;
                me_q       <= 1'b0;
                cnt_q      <= '0;
                rof_q      <= 1'b0;
                stampclr_q <= 1'b1;
                ev0we_q    <= 1'b1;
                ev0val_q   <= '0;
            end
            if (sweep_done) begin
                busy_q   <= 1'b0;
                memclr_q <= 1'b1;
            end
        end
    end

    assign stamp_cap_o = stamp_q;
    assign stamp_clr_o = stampclr_q;
    assign ev0_we_o    = ev0we_q;
    assign ev0_val_o   = ev0val_q;
    assign mip_o       = mip_q;
    assign me_o        = me_q;
    assign mem_clr_o   = memclr_q;
    assign clr_en_o    = clren_q;
    assign busy_o      = busy_q;
    assign rof_o       = rof_q;
    assign etc_o       = etc;
    assign evt_cnt_o   = cnt_q;

    AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(mip_q) |-> ($past(memclr_q) && $past(res_sel_i) != 2'b00 &&
                          $past(trig_sel_i) != 2'b00 && $past(osc_en_i))); // R3
    AST_START_STAMPS: assert property (@(posedge clk) disable iff (rst)
        $rose(mip_q) |-> (stamp_q && ev0we_q && ev0val_q == '0)); // R4
    AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (rst)
        $fell(mip_q) |-> !me_q); // R11
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(sweep_go) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1))); // R7
    AST_BUSY_NO_MISSION: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !mip_q); // R2

endmodule

// File: tb/evlog_mission_ctrl_tb.sv
module evlog_mission_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_i = 0, tick_sec_i = 0, tick_min_i = 0, tick_hr_i = 0;
    logic [1:0]  res_sel_i = 2'b01, trig_sel_i = 2'b01;
    logic        osc_en_i = 1, roll_en_i = 0;
    logic        arm_wr_i = 0, arm_val_i = 0, mip_wr_i = 0, mip_val_i = 0;
    logic        clren_wr_i = 0, clrmem_wr_i = 0, reg_wr_i = 0;
    logic        log_we_o, stamp_cap_o, stamp_clr_o, ev0_we_o;
    logic [10:0] log_addr_o, wptr_o;
    logic [7:0]  log_wdata_o;
    logic [15:0] ev0_val_o, etc_o;
    logic        mip_o, me_o, mem_clr_o, clr_en_o, busy_o, rof_o;
    logic [23:0] evt_cnt_o;

    int total = 0, bad = 0, wr_cnt = 0, stamp_cnt = 0, sclr_cnt = 0;
    int entries = 0;
    logic [15:0] e0_last = 16'h1234;
    logic [7:0]  mem [0:2047];
    int          exp_val [0:1023];
    bit          done = 0;

    always #2 clk = ~clk;

    evlog_mission_ctrl dut_i (.*);

    always @(posedge clk) begin
        if (log_we_o) begin
            mem[log_addr_o] <= log_wdata_o;
            wr_cnt <= wr_cnt + 1;
        end
        if (stamp_cap_o) stamp_cnt <= stamp_cnt + 1;
        if (stamp_clr_o) sclr_cnt <= sclr_cnt + 1;
        if (ev0_we_o) e0_last <= ev0_val_o;
    end

    function automatic logic [15:0] entry_word(input int idx);
        return {mem[2*idx+1], mem[2*idx]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    task automatic do_mip(input logic v);
        mip_val_i = v; pulse(mip_wr_i);
    endtask

    task automatic do_arm(input logic v);
        arm_val_i = v; pulse(arm_wr_i);
    endtask

    task automatic fire_evt();
        pulse(evt_i); cyc(3);
    endtask

    task automatic tick(input int k);
        if (k == 0) pulse(tick_sec_i);
        else if (k == 1) pulse(tick_min_i);
        else pulse(tick_hr_i);
    endtask

    task automatic hr_burst(input int n);
        @(negedge clk) tick_hr_i = 1'b1;
        repeat (n - 1) @(negedge clk);
        @(negedge clk) tick_hr_i = 1'b0;
        cyc(4);
    endtask

    task automatic do_clear();
        int w0;
        int guard;
        w0 = wr_cnt;
        pulse(clren_wr_i);
        pulse(clrmem_wr_i);
        chk("R2 busy", busy_o, 1);
        guard = 0;
        while (!mem_clr_o && guard < 3000) begin cyc(1); guard++; end
        cyc(2);
        chk("R2 sweep writes", wr_cnt - w0, 2048);
        chk("R2 busy drop", busy_o, 0);
        chk("R2 count zero", evt_cnt_o, 0);
        chk("R2 ptr zero", wptr_o, 0);
        chk("R2 rof zero", rof_o, 0);
        entries = 0;
    endtask

    task automatic random_events(input int n, input int sel);
        for (int e = 0; e < n; e++) begin
            int nt;
            int hits;
            nt = $urandom_range(0, 40);
            hits = 0;
            for (int j = 0; j < nt; j++) begin
                int k;
                k = $urandom_range(0, 2);
                tick(k);
                if (k == sel) hits++;
            end
            fire_evt();
            exp_val[entries] = hits;
            entries++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int w0;
        int s0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 2048; i++) mem[i] = 8'hAA;
        cyc(5);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1 mip", mip_o, 0);
        chk("R1 me", me_o, 0);
        chk("R1 memclr", mem_clr_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 count", evt_cnt_o, 0);
        chk("R1 ptr", wptr_o, 0);
        chk("R1 writes", wr_cnt, 0);

        // R3 start refused before any clear
        do_mip(1'b1); cyc(1);
        chk("R3 no start uncleared", mip_o, 0);

        // R2 cancelled clear
        pulse(clren_wr_i);
        chk("R2 clren set", clr_en_o, 1);
        pulse(reg_wr_i);
        chk("R2 clren cancel", clr_en_o, 0);
        pulse(clrmem_wr_i); cyc(2);
        chk("R2 no clear after cancel", busy_o | mem_clr_o, 0);

        do_clear();
        chk("R2 memclr", mem_clr_o, 1);
        chk("R2 stamp clr", sclr_cnt, 1);
        chk("R2 log byte 0", mem[0], 0);
        chk("R2 log byte last", mem[2047], 0);

        // R3 invalid configurations
        res_sel_i = 2'b00; do_mip(1'b1); cyc(1);
        chk("R3 res off", mip_o, 0);
        res_sel_i = 2'b01; trig_sel_i = 2'b00; do_mip(1'b1); cyc(1);
        chk("R3 trig off", mip_o, 0);
        trig_sel_i = 2'b11; osc_en_i = 1'b0; do_arm(1'b1); cyc(1);
        chk("R3 arm refused", me_o, 0);
        osc_en_i = 1'b1;

        // R12 idle event ignored
        w0 = wr_cnt;
        fire_evt();
        chk("R12 no write", wr_cnt - w0, 0);
        chk("R12 no count", evt_cnt_o, 0);

        // R4 immediate start, seconds resolution
        s0 = stamp_cnt;
        do_mip(1'b1); cyc(1);
        chk("R4 mip", mip_o, 1);
        chk("R4 me", me_o, 1);
        chk("R4 count", evt_cnt_o, 1);
        chk("R4 memclr drop", mem_clr_o, 0);
        chk("R4 stamp", stamp_cnt - s0, 1);
        chk("R4 ev0", e0_last, 0);

        // R6 R7 random entries
        random_events(20, 0);
        for (int i = 0; i < 20; i++) chk("R6 R7 entry sec", entry_word(i), exp_val[i]);
        chk("R7 ptr", wptr_o, 40);
        chk("R7 count", evt_cnt_o, 21);
        chk("R7 etc restart", etc_o, 0);

        // R11 stop by any write
        pulse(reg_wr_i); cyc(2);
        chk("R11 mip clear", mip_o, 0);
        chk("R11 me clear", me_o, 0);
        tick(0); tick(0);
        chk("R11 etc frozen", etc_o, 0);
        w0 = wr_cnt;
        fire_evt();
        chk("R12 after stop", evt_cnt_o, 21);
        chk("R12 no write after stop", wr_cnt - w0, 0);
        do_mip(1'b1); cyc(1);
        chk("R3 no restart", mip_o, 0);

        // R5 armed start, minutes, no rollover
        do_clear();
        res_sel_i = 2'b10; roll_en_i = 1'b0;
        do_arm(1'b1);
        chk("R5 armed", me_o, 1);
        chk("R5 not running", mip_o, 0);
        w0 = wr_cnt;
        fire_evt();
        chk("R5 started", mip_o, 1);
        chk("R5 count", evt_cnt_o, 1);
        chk("R5 no entry", wr_cnt - w0, 0);
        random_events(10, 1);
        for (int i = 0; i < 10; i++) chk("R6 entry min", entry_word(i), exp_val[i]);
        // R9 fill then drop
        while (entries < 1024) begin fire_evt(); entries++; end
        cyc(2);
        chk("R9 ptr wrap", wptr_o, 0);
        chk("R9 rof", rof_o, 1);
        w0 = wr_cnt;
        fire_evt(); fire_evt(); fire_evt();
        chk("R9 no writes", wr_cnt - w0, 0);
        chk("R9 counted", evt_cnt_o, 1028);
        chk("R9 byte 0 kept", entry_word(0), exp_val[0]);
        pulse(reg_wr_i); cyc(2);

        // R8 saturation, R10 rollover, hours
        do_clear();
        res_sel_i = 2'b11; roll_en_i = 1'b1;
        do_mip(1'b1); cyc(1);
        hr_burst(65535);
        chk("R8 sat entry", entry_word(0), 16'hFFFF);
        chk("R8 ptr", wptr_o, 2);
        chk("R8 count unchanged", evt_cnt_o, 1);
        chk("R8 etc restart", etc_o, 0);
        hr_burst(5);
        tick(0); tick(1);
        fire_evt();
        chk("R6 entry hr", entry_word(1), 5);
        entries = 2;
        while (entries < 1024) begin fire_evt(); entries++; end
        cyc(2);
        chk("R10 full no rof yet", rof_o, 0);
        chk("R10 ptr", wptr_o, 0);
        hr_burst(7);
        w0 = wr_cnt; s0 = stamp_cnt;
        fire_evt();
        chk("R10 restamp", stamp_cnt - s0, 1);
        chk("R10 ev0 delta", e0_last, 7);
        chk("R10 rof", rof_o, 1);
        chk("R10 no log write", wr_cnt - w0, 0);
        hr_burst(3);
        fire_evt();
        chk("R10 entry at 0", entry_word(0), 3);
        chk("R10 ptr after", wptr_o, 2);
        chk("R10 count", evt_cnt_o, 1026);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule